// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels gets the next tenure on a shared external bus. Priority is fixed: channel 0 wins over channel 1, which wins over channel 2, with channel 3 last. The one exception is that the channel that has just given up the bus is passed over whenever any other channel is asking. That channel is granted again only if no other channel wants the bus.

A granted channel keeps the bus until the transfer engine reports that it is done. That report is ignored while the lock input marks a burst, or a block in block mode, as still running. When the bus is given up, the bus never passes straight from one channel to the next. If another bus master is asking, it gets a one-cycle grant. If not, the arbiter holds the bus idle for exactly one cycle. Request lines are sampled in that in-between cycle, and the selected channel is granted on the following cycle.

There is no data path here, so there is no valid/ready handshake. Every pin is a plain level-sensitive control or status signal sampled on the rising clock edge. All outputs are driven straight from flip-flops.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `chan_gnt` is 0000, `ext_gnt` is 0 and `bus_idle` is 0, and no channel is recorded as the previous owner.
- R2: With the bus free and `ext_req` low, a request seen at an edge is granted on the next cycle to the lowest-numbered requesting channel. `chan_gnt` bit i means channel i and is never more than one-hot.
- R3: While a channel is granted and `xfer_done` is low, the grant does not change, whatever the request lines do.
- R4: While `lock` is high, `xfer_done` is ignored and the current grant stays in place.
- R5: When `xfer_done` is high, `lock` is low and `ext_req` is high, the next cycle has `ext_gnt` high for exactly one cycle, with `chan_gnt` at zero.
- R6: When `xfer_done` is high, `lock` is low and `ext_req` is low, the next cycle has `bus_idle` high for exactly one cycle, with `chan_gnt` at zero.
- R7: Requests sampled during the `ext_gnt` or `bus_idle` cycle are granted on the next cycle to the lowest-numbered requester other than the previous owner.
- R8: If the previous owner is the only channel requesting in that cycle, it is granted again.
- R9: If no channel requests in that cycle, all outputs go low and the previous-owner record is cleared, so the next selection uses plain priority.
- R10: With the bus free (all outputs low), a high `ext_req` gives a one-cycle `ext_gnt` ahead of any channel request. The channel selection then follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 4 | Transfer request per channel, bit 0 highest priority |
| xfer_done | input | 1 | Granted channel is giving up the bus this cycle |
| lock | input | 1 | Burst or block still running; hold the current channel |
| ext_req | input | 1 | Bus request from a master outside the DMA controller |
| chan_gnt | output | 4 | One-hot channel grant |
| ext_gnt | output | 1 | One-cycle bus grant to the outside master |
| bus_idle | output | 1 | One-cycle idle bus between two channel tenures |

## Verification
The properties assume that `xfer_done` and `lock` are meaningful only while a channel holds a grant. Outside a grant the design ignores them. The outside master is taken to need only a single cycle per turn. The stimulus draws the request lines, `xfer_done`, `lock` and `ext_req` at random from a fixed seed, with `lock` and `ext_req` kept sparse so that releases happen often. Directed sequences are run before the random ones to reach the previous-owner exclusion, sole-owner regrant, record clearing and free-bus external grant in a known order.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_OWN  = 2'd1,
    ST_EXT  = 2'd2,
    ST_GAP  = 2'd3
  } arb_st_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/dma_idx_onehot.sv
module dma_idx_onehot #(
  parameter int NCH = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            en,
  input  logic [IDXW-1:0] idx,
  output logic [NCH-1:0]  oh
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign oh[g] = en && (idx == IDXW'(g));
  end
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_done,
  input  logic            lock,
  input  logic            ext_req,
  input  logic            cand_any,
  input  logic [IDXW-1:0] cand_idx,
  input  logic            self_req,
  output logic [IDXW-1:0] cur_idx,
  output logic            cur_vld,
  output logic [NCH-1:0]  chan_gnt,
  output logic            ext_gnt,
  output logic            bus_idle
);
  arb_st_e         st_q, st_d;
  logic [IDXW-1:0] idx_d;
  logic            vld_d;
  logic [NCH-1:0]  gnt_d;

  always_comb begin
    st_d  = st_q;
    idx_d = cur_idx;
    vld_d = cur_vld;
    unique case (st_q)
      ST_FREE: begin
        if (ext_req) begin
          st_d = ST_EXT;
        end else if (cand_any) begin
          st_d  = ST_OWN;
          idx_d = cand_idx;
          vld_d = 1'b1;
        end
      end
      ST_OWN: begin
        if (xfer_done && !lock) st_d = ext_req ? ST_EXT : ST_GAP;
      end
      default: begin
        // in-between cycle: pick the next owner
        if (cand_any) begin
          st_d  = ST_OWN;
          idx_d = cand_idx;
          vld_d = 1'b1;
        end else if (self_req) begin
          st_d = ST_OWN;
        end else begin
          st_d  = ST_FREE;
          vld_d = 1'b0;
        end
      end
    endcase
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      gnt_d[i] = (st_d == ST_OWN) && (idx_d == IDXW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_FREE;
      cur_idx  <= '0;
      cur_vld  <= 1'b0;
      chan_gnt <= '0;
      ext_gnt  <= 1'b0;
      bus_idle <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_idx  <= idx_d;
      cur_vld  <= vld_d;
      chan_gnt <= gnt_d;
      ext_gnt  <= (st_d == ST_EXT);
      bus_idle <= (st_d == ST_GAP);
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic           xfer_done,
  input  logic           lock,
  input  logic           ext_req,
  output logic [NCH-1:0] chan_gnt,
  output logic           ext_gnt,
  output logic           bus_idle
);
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IDXW-1:0] cur_idx;
  logic            cur_vld;
  logic [NCH-1:0]  cur_oh;
  logic [NCH-1:0]  cand_req;
  logic            cand_any;
  logic [IDXW-1:0] cand_idx;
  logic            self_req;

  dma_idx_onehot #(.NCH(NCH)) u_cur_dec (
    .en  (cur_vld),
    .idx (cur_idx),
    .oh  (cur_oh)
  );

  // previous owner is excluded from the candidate set
  assign cand_req = chan_req & ~cur_oh;
  assign self_req = |(chan_req & cur_oh);

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req (cand_req),
    .any (cand_any),
    .idx (cand_idx)
  );

  dma_arb_fsm #(.NCH(NCH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_done (xfer_done),
    .lock      (lock),
    .ext_req   (ext_req),
    .cand_any  (cand_any),
    .cand_idx  (cand_idx),
    .self_req  (self_req),
    .cur_idx   (cur_idx),
    .cur_vld   (cur_vld),
    .chan_gnt  (chan_gnt),
    .ext_gnt   (ext_gnt),
    .bus_idle  (bus_idle)
  );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_req,
  input logic           xfer_done,
  input logic           lock,
  input logic           ext_req,
  input logic [NCH-1:0] chan_gnt,
  input logic           ext_gnt,
  input logic           bus_idle
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_gnt) && !xfer_done) |=> (chan_gnt == $past(chan_gnt)));

  assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_gnt) && lock) |=> (chan_gnt == $past(chan_gnt)));

  assert_ext_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_gnt) && xfer_done && !lock && ext_req) |=> (ext_gnt && chan_gnt == '0));

  assert_ext_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt |=> !ext_gnt);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_gnt || bus_idle) |-> (chan_gnt == '0 && !(ext_gnt && bus_idle)));

  assert_gap_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_gnt) && xfer_done && !lock && !ext_req) |=> bus_idle);

  assert_gap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> !bus_idle);

  assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_gnt || bus_idle) |=> ((chan_gnt & ~$past(chan_req)) == '0));

  assert_free_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_gnt == '0 && !ext_gnt && !bus_idle && ext_req) |=> ext_gnt);
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_req  (chan_req),
  .xfer_done (xfer_done),
  .lock      (lock),
  .ext_req   (ext_req),
  .chan_gnt  (chan_gnt),
  .ext_gnt   (ext_gnt),
  .bus_idle  (bus_idle)
);

// File: tb/dma_prio_arb_bench.sv
`timescale 1ns/1ps
module dma_prio_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] chan_req = '0;
  logic       xfer_done = 1'b0;
  logic       lock = 1'b0;
  logic       ext_req = 1'b0;
  logic [3:0] chan_gnt;
  logic       ext_gnt;
  logic       bus_idle;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  dma_prio_arb u_dma_prio_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_req  (chan_req),
    .xfer_done (xfer_done),
    .lock      (lock),
    .ext_req   (ext_req),
    .chan_gnt  (chan_gnt),
    .ext_gnt   (ext_gnt),
    .bus_idle  (bus_idle)
  );

  // model: 0 free, 1 owned, 2 outside master, 3 idle gap
  int    m_st = 0;
  int    m_cur = 0;
  bit    m_vld = 1'b0;
  string m_tag = "R1";

  function automatic int lowest(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [3:0] exp_gnt();
    return (m_st == 1) ? 4'(1 << m_cur) : 4'b0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_vld = 1'b0; m_cur = 0; m_tag = "R1";
    end else begin
      case (m_st)
        0: begin
          if (ext_req) begin m_st = 2; m_tag = "R10"; end
          else if (|chan_req) begin
            m_st = 1; m_cur = lowest(chan_req); m_vld = 1'b1; m_tag = "R2";
          end else m_tag = "R9";
        end
        1: begin
          if (xfer_done && !lock) begin
            m_st = ext_req ? 2 : 3; m_tag = ext_req ? "R5" : "R6";
          end else m_tag = (xfer_done && lock) ? "R4" : "R3";
        end
        default: begin
          logic [3:0] c;
          c = m_vld ? (chan_req & ~4'(1 << m_cur)) : chan_req;
          if (|c) begin
            m_tag = m_vld ? "R7" : "R9";
            m_st = 1; m_cur = lowest(c); m_vld = 1'b1;
          end else if (m_vld && chan_req[m_cur]) begin
            m_st = 1; m_tag = "R8";
          end else begin
            m_st = 0; m_vld = 1'b0; m_tag = "R9";
          end
        end
      endcase
    end
  end

  task automatic compare();
    logic [3:0] eg;
    logic ee, ei;
    eg = exp_gnt();
    ee = (m_st == 2);
    ei = (m_st == 3);
    n_cmp++;
    if (chan_gnt !== eg || ext_gnt !== ee || bus_idle !== ei) begin
      n_bad++;
      $display("FAIL %s: gnt=%b ext=%b idle=%b, expected gnt=%b ext=%b idle=%b",
               m_tag, chan_gnt, ext_gnt, bus_idle, eg, ee, ei);
    end
  endtask

  task automatic step(input logic [3:0] rq, input logic dn, input logic lk, input logic ex);
    @(negedge clk);
    compare();
    chan_req = rq; xfer_done = dn; lock = lk; ext_req = ex;
  endtask

  initial begin
    void'($urandom(32'd7321));
    // R1: reset state
    repeat (2) step(4'b1111, 1'b1, 1'b0, 1'b1);
    step(4'b0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(4'b0110, 1'b0, 1'b0, 1'b0);  // R2: ch1 wins over ch2
    step(4'b1111, 1'b0, 1'b0, 1'b0);  // R3: hold despite ch0
    step(4'b0011, 1'b1, 1'b1, 1'b0);  // R4: done while locked
    step(4'b0011, 1'b1, 1'b0, 1'b0);  // R6: gap
    step(4'b0011, 1'b0, 1'b0, 1'b0);  // R7: ch1 excluded, ch0 next
    step(4'b0001, 1'b1, 1'b0, 1'b1);  // R5: outside master cycle
    step(4'b0001, 1'b0, 1'b0, 1'b0);  // R8: sole owner regrant
    step(4'b0000, 1'b1, 1'b0, 1'b0);  // R6 gap
    step(4'b0000, 1'b0, 1'b0, 1'b0);  // R9: nobody asks
    step(4'b0000, 1'b0, 1'b0, 1'b1);  // R10: free bus, outside master
    step(4'b0011, 1'b0, 1'b0, 1'b0);  // R9: record cleared -> ch0
    step(4'b1000, 1'b1, 1'b0, 1'b0);
    step(4'b1000, 1'b0, 1'b0, 1'b0);  // R7: ch3 after ch0
    step(4'b0000, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] rq;
      rq = 4'($urandom);
      step(rq, ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    step(4'b0000, 1'b0, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1..: run still going, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule